// File: doc/BRIEF.md
# Flux Window Separator

This block turns the raw flux-transition line of a floppy drive into a recovered data window for an MFM read channel. Every register sits on a single master clock. The block's logic moves only on master-clock edges where a rate enable is high. That enable must pulse at sixteen times the nominal data rate. No internal signal drives a clock pin, so one clock constraint covers the whole path.

The read line is asynchronous. It passes through a chain of synchronizer flops that sample on every master-clock edge. A rising edge found there is kept as a pending request until the next enabled tick. On that tick the block starts a reshaped data pulse that lasts a fixed number of ticks. On the same tick it clears an 8-bit twisted-ring phase counter. The counter shifts in the inverse of its own top bit, so with no input it fills with ones over 8 ticks and then empties over 8 ticks. The window output flips one tick after each change of the counter's top bit. A flux pulse therefore jerks the window phase into line with the incoming data, with no filtering, which pulls the next edge earlier or later. Downstream logic samples the reshaped pulse against the window to assemble bits.

The ports carry no data stream, so there is no handshake. The rate enable acts as the only flow control, and it cannot be back-pressured.

Top module: `flux_window_sep`

## Requirements
- R1: A rising edge on `rd_flux`, driven just after a clock edge, is seen after two synchronizer stages. With `tick_en` held high, `data_pulse` is low after the second following clock edge and high after the third.
- R2: Each detected flux edge makes `data_pulse` high for exactly two enabled ticks, whatever the spacing of the ticks.
- R3: With no flux edges and `tick_en` high on every clock, `data_window` first goes high on the 9th enabled edge after reset. It then changes on every 8th tick, so one window period is 16 ticks.
- R4: The tick that starts a data pulse clears the phase counter to zero. This takes priority over shifting. The next rise of the counter's top bit comes 8 ticks later, and the window flips one tick after that. A pulse while the top bit is low delays the window. A pulse while it is high makes the window flip on the very next tick, which advances it.
- R5: `data_window` changes only on an enabled tick. It changes exactly when the counter's top bit, as registered on the previous tick, differs from the top bit now, so it tracks both the filling and the emptying half of the count.
- R6: While `tick_en` is low, `data_pulse`, `data_window` and the phase counter hold their values.
- R7: A flux edge that arrives between ticks, even one that lasts a single clock, is held pending. It starts a pulse on the next enabled tick and is not lost.
- R8: While `rst_n` (active low, synchronous) is sampled low, the synchronizer, the pending flag, the phase counter, `data_pulse` and `data_window` are all cleared to 0.
- R9: A flux line that stays high gives a single data pulse. Only a low-to-high change counts as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Rate enable, high for one clock per tick (16 ticks per bit cell) |
| rd_flux | input | 1 | Asynchronous read line, rises on each flux transition |
| data_pulse | output | 1 | Reshaped data pulse, two ticks wide |
| data_window | output | 1 | Recovered data window |

## Verification
The assertions assume that `tick_en` is a clean synchronous signal and that flux edges come at least a few ticks apart. A new edge during a live pulse would restart it, and the pulse-length check would not apply to that case. The bench drives `rd_flux` and `tick_en` only at falling clock edges. It spaces each flux edge far from the next one. It uses either a tick on every clock or a fixed one-in-four tick pattern, so every expected edge falls on a known cycle.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int unsigned FWS_SYNC_STAGES  = 2;
  localparam int unsigned FWS_PULSE_TICKS  = 2;
  localparam int unsigned FWS_RING_W       = 8;
endpackage

// File: rtl/fws_flux_capture.sv
module fws_flux_capture #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic rd_flux,
  output logic fire,
  output logic pending
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              rise;

  // synchronizer chain, runs on every clock regardless of the enable
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= rd_flux;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // an edge is kept until a tick consumes it
  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= 1'b0;
    else if (tick_en) pending <= 1'b0;
    else if (rise)    pending <= 1'b1;
  end

  assign fire = tick_en & (pending | rise);
endmodule

// File: rtl/fws_pulse_shaper.sv
module fws_pulse_shaper #(
  parameter int unsigned PULSE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic fire,
  output logic data_pulse
);
  localparam int unsigned CW = $clog2(PULSE_TICKS + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (tick_en) begin
      if (fire)              left_q <= CW'(PULSE_TICKS);
      else if (left_q != '0) left_q <= left_q - CW'(1);
    end
  end

  assign data_pulse = (left_q != '0);
endmodule

// File: rtl/fws_phase_ring.sv
module fws_phase_ring #(
  parameter int unsigned RING_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              fire,
  output logic [RING_W-1:0] ring,
  output logic              data_window
);
  logic top_q;
  logic top_moved;

  assign top_moved = ring[RING_W-1] ^ top_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring        <= '0;
      top_q       <= 1'b0;
      data_window <= 1'b0;
    end else if (tick_en) begin
      if (fire) ring <= '0;
      else      ring <= {ring[RING_W-2:0], ~ring[RING_W-1]};
      top_q       <= ring[RING_W-1];
      data_window <= data_window ^ top_moved;
    end
  end
endmodule

// File: rtl/flux_window_sep.sv
module flux_window_sep
  import fws_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = FWS_SYNC_STAGES,
  parameter int unsigned PULSE_TICKS = FWS_PULSE_TICKS,
  parameter int unsigned RING_W      = FWS_RING_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic rd_flux,
  output logic data_pulse,
  output logic data_window
);
  logic              fire;
  logic              pending;
  logic [RING_W-1:0] ring;

  fws_flux_capture #(.STAGES(SYNC_STAGES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .rd_flux (rd_flux),
    .fire    (fire),
    .pending (pending)
  );

  fws_pulse_shaper #(.PULSE_TICKS(PULSE_TICKS)) u_shape (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .fire       (fire),
    .data_pulse (data_pulse)
  );

  fws_phase_ring #(.RING_W(RING_W)) u_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .fire        (fire),
    .ring        (ring),
    .data_window (data_window)
  );
endmodule

// File: rtl/flux_window_sep_chk.sv
module flux_window_sep_chk #(
  parameter int unsigned RING_W      = 8,
  parameter int unsigned PULSE_TICKS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              fire,
  input logic              pending,
  input logic [RING_W-1:0] ring,
  input logic              data_pulse,
  input logic              data_window
);
  logic [RING_W-1:0] ring_inc;
  logic [RING_W-1:0] ring_inv_inc;
  logic              ring_legal;
  logic [7:0]        hi_ticks;

  assign ring_inc     = ring + {{(RING_W-1){1'b0}}, 1'b1};
  assign ring_inv_inc = ~ring + {{(RING_W-1){1'b0}}, 1'b1};
  assign ring_legal   = ((ring & ring_inc) == '0) || ((~ring & ring_inv_inc) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || fire)          hi_ticks <= '0;
    else if (!data_pulse)        hi_ticks <= '0;
    else if (tick_en && hi_ticks != 8'hFF) hi_ticks <= hi_ticks + 8'd1;
  end

  // R8
  rst_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (!data_pulse && !data_window && ring == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(data_window) && $stable(data_pulse) && $stable(ring)));

  // R4
  clear_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ring == '0 && data_pulse));

  // R7
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !tick_en) |=> pending);

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks <= 8'(PULSE_TICKS));

  // R3
  ring_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_legal);
endmodule

bind flux_window_sep flux_window_sep_chk #(
  .RING_W      (RING_W),
  .PULSE_TICKS (PULSE_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .fire        (fire),
  .pending     (pending),
  .ring        (ring),
  .data_pulse  (data_pulse),
  .data_window (data_window)
);

// File: tb/flux_window_sep_tb.sv
`timescale 1ns/1ps
module flux_window_sep_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic rd_flux = 1'b0;
  logic data_pulse;
  logic data_window;

  int errors = 0;
  int checks = 0;
  int edge_n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flux_window_sep u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .rd_flux     (rd_flux),
    .data_pulse  (data_pulse),
    .data_window (data_window)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  // go to just after the given enabled edge (counted from reset release)
  task automatic goto(input int target);
    while (edge_n < target) begin
      @(posedge clk);
      edge_n++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; rd_flux = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; tick_en = 1'b1;
    edge_n = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 pulse after reset", data_pulse, 0);
    chk("R8 window after reset", data_window, 0);
    goto(12);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 window cleared mid-run", data_window, 0);
    chk("R8 pulse cleared mid-run", data_pulse, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_free_run();
    do_reset();
    goto(8);  chk("R3 window before 9th tick", data_window, 0);
    goto(9);  chk("R3 window at 9th tick", data_window, 1);
    goto(16); chk("R5 window held", data_window, 1);
    goto(17); chk("R5 window after fall of top bit", data_window, 0);
    goto(24); chk("R3 window low half", data_window, 0);
    goto(25); chk("R3 window period 16 ticks", data_window, 1);
  endtask

  task automatic t_delay();
    do_reset();
    goto(2);  rd_flux = 1'b1;
    goto(4);  chk("R1 pulse not yet after 2 edges", data_pulse, 0);
    goto(5);  chk("R1 pulse after 3 edges", data_pulse, 1);
    goto(6);  chk("R2 pulse second tick", data_pulse, 1);
    goto(7);  chk("R2 pulse ends after two ticks", data_pulse, 0);
    goto(9);  chk("R4 delayed window held low", data_window, 0);
    goto(13); chk("R4 delayed window still low", data_window, 0);
    goto(14); chk("R4 window 9 ticks after clear", data_window, 1);
    begin
      int extra = 0;
      for (int i = 15; i <= 40; i++) begin
        goto(i);
        if (data_pulse) extra++;
      end
      chk("R9 held line gives one pulse", extra, 0);
    end
    rd_flux = 1'b0;
  endtask

  task automatic t_advance();
    do_reset();
    goto(12); rd_flux = 1'b1;
    goto(15); chk("R4 window before jerk", data_window, 1);
    chk("R1 pulse at third edge", data_pulse, 1);
    goto(16); chk("R4 advanced flip next tick", data_window, 0);
    rd_flux = 1'b0;
    goto(23); chk("R4 window low before rise", data_window, 0);
    goto(24); chk("R4 window rises 9 ticks after clear", data_window, 1);
  endtask

  task automatic t_freeze();
    int moved = 0;
    int pulsed = 0;
    do_reset();
    goto(10); tick_en = 1'b0;
    goto(12); rd_flux = 1'b1;
    goto(13); rd_flux = 1'b0;
    for (int i = 14; i <= 30; i++) begin
      goto(i);
      if (data_window != 1'b1) moved++;
      if (data_pulse) pulsed++;
    end
    chk("R6 window frozen without ticks", moved, 0);
    chk("R6 no pulse without ticks", pulsed, 0);
    tick_en = 1'b1;
    goto(31); chk("R7 pending edge fires on next tick", data_pulse, 1);
    goto(32); chk("R4 jerk flips window", data_window, 0);
    chk("R2 pulse second tick", data_pulse, 1);
    goto(33); chk("R2 pulse ended", data_pulse, 0);
    goto(39); chk("R4 window low before rise", data_window, 0);
    goto(40); chk("R4 window rises after clear", data_window, 1);
  endtask

  task automatic t_slow_rate();
    int hi = 0;
    int rises = 0;
    int chg[$];
    logic prev_p = 1'b0;
    logic prev_w = 1'b0;
    do_reset();
    tick_en = 1'b0;
    for (int i = 0; i < 240; i++) begin
      @(negedge clk);
      if (data_pulse) hi++;
      if (data_pulse && !prev_p) rises++;
      if (data_window != prev_w && i < 150) chg.push_back(i);
      prev_p = data_pulse;
      prev_w = data_window;
      tick_en = (i % 4 == 3);
      rd_flux = (i == 161);
    end
    tick_en = 1'b1;
    rd_flux = 1'b0;
    chk("R2 pulse 8 clocks at one-in-four ticks", hi, 8);
    chk("R7 one-clock flux edge caught", rises, 1);
    chk("R3 window changes seen", (chg.size() >= 3) ? 1 : 0, 1);
    if (chg.size() >= 3) begin
      chk("R3 half period 32 clocks", chg[1] - chg[0], 32);
      chk("R5 half period 32 clocks", chg[2] - chg[1], 32);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_free_run();
    t_delay();
    t_advance();
    t_freeze();
    t_slow_rate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule